// File: doc/BRIEF.md
# Vicinity-card tag emulator command responder

This block supplies the answer side of an emulated 13.56 MHz vicinity card. A frame decoder in front of it delivers one reader command at a time: the opcode byte, the block-number byte, the total byte count of the frame and the subcarrier-tick timestamp of the reader's end of frame. The responder classifies the command and picks a payload from one of three sources: a constant pattern, a preset word, or its own byte memory of 8-byte blocks. It then streams the payload to a tag transmitter with a CRC-16 appended. With each reply it presents a start tick, which the transmitter compares against its free-running tick counter.

A mode input selects between restricted emulation and full emulation. In restricted mode only a handful of fixed answers exist. In full mode the block memory is served, including a four-block burst read. The two key blocks never reveal memory on a single-block read. A byte-wide load port fills the block memory before emulation starts.

Top module: `tag_responder`

## Requirements
- R1: An activate-all command (opcode 0x0A, frame length of at least 1 byte, either mode) yields one transmit beat with tx_empty=1 and tx_last=1, carrying no data bytes. Any frame of length 0 yields no reply.
- R2: A read command (opcode 0x0C, block number in the second byte) is answered only when the frame length is exactly 4. Any other length gives no reply.
- R3: A single-block read of key block 3 or 4 returns eight 0xFF bytes followed by the CRC, in both modes. The memory content is not shown.
- R4: In full mode, a single-block read of any other block returns memory bytes block*8 to block*8+7 in address order, then the CRC, for 10 beats in total.
- R5: In full mode, a burst read (opcode 0x06, length exactly 4) returns the 32 memory bytes from block*8 upward, then a CRC over all 32, for 34 beats. In restricted mode, or with any other length, it gives no reply.
- R6: In restricted mode, reads of blocks 0, 1, 2 and 5 return the preset word of that block, low byte first, then the CRC. Every other block number gets no reply.
- R7: An update command (opcode 0x87) and any unknown opcode produce no reply, and the block is ready for the next frame one cycle later.
- R8: The two CRC bytes follow the payload, low byte first. The CRC is a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) taken over the payload bytes and then inverted.
- R9: While a reply is on the stream, tx_start_tick equals the frame's end-of-frame tick plus 132, wrapping at the tick width.
- R10: frame_ready is high exactly while no reply is pending. A frame that earns a reply raises tx_valid in the next cycle.
- R11: While tx_valid is high and tx_ready is low, tx_data, tx_last, tx_empty and tx_start_tick hold their values.
- R12: Memory addresses wrap modulo NUM_BLOCKS*8. In full mode, the block number is reduced modulo NUM_BLOCKS before the key-block test, so an alias of block 3 or 4 also reads back as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_mode | input | 1 | 1 = full emulation, 0 = restricted |
| frame_valid | input | 1 | A decoded reader frame is offered |
| frame_ready | output | 1 | Responder idle, frame accepted this cycle |
| frame_len | input | $clog2(MAX_FRAME_BYTES+1) | Byte count of the frame |
| frame_head | input | 16 | Bits 7:0 opcode, bits 15:8 block number |
| frame_eof_tick | input | TICK_W | Subcarrier tick of the reader end of frame |
| load_en | input | 1 | Write one byte into the block memory |
| load_addr | input | $clog2(NUM_BLOCKS*8) | Byte address for the load |
| load_data | input | 8 | Byte to load |
| tx_valid | output | 1 | Reply beat available |
| tx_ready | input | 1 | Transmitter takes the beat |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final beat of the reply |
| tx_empty | output | 1 | Beat carries no byte (start-of-frame-only reply) |
| tx_start_tick | output | TICK_W | Tick at which the reply must start |

## Verification
The bench builds the responder with NUM_BLOCKS=8, which gives a 64-byte memory. With that size, a burst read starting at block 6 wraps past the top of memory, and block numbers 9, 11 and 12 alias blocks 1, 3 and 4. The alias reads show both the address wrap and the key-block masking after reduction. End-of-frame ticks near the top of the 32-bit range push the start tick through its wrap. Random back-pressure on tx_ready keeps every reply stalling mid-stream.

// File: rtl/tr_pkg.sv
package tr_pkg;

   typedef enum logic [2:0] {
      RK_NONE   = 3'd0,
      RK_SOF    = 3'd1,
      RK_FF     = 3'd2,
      RK_PRESET = 3'd3,
      RK_MEM    = 3'd4
   } resp_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SOF  = 3'd1,
      ST_DATA = 3'd2,
      ST_CRC0 = 3'd3,
      ST_CRC1 = 3'd4
   } seq_state_e;

   localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
   localparam logic [15:0] CRC_PRESET    = 16'hFFFF;

   function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c ^ {8'h00, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/tr_crc16.sv
module tr_crc16
   import tr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       update,
   input  logic [7:0] din,
   output logic [15:0] crc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc <= CRC_PRESET;
      else if (clear)  crc <= CRC_PRESET;
      else if (update) crc <= crc16_byte(crc, din);
   end

   AST_CRC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc == CRC_PRESET)); // R8

   AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !update) |=> $stable(crc)); // R8

endmodule

// File: rtl/tr_blockmem.sv
module tr_blockmem #(
   parameter int NUM_BYTES = 256,
   parameter int AW        = 8
) (
   input  logic          clk,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);

   logic [7:0] mem_q [NUM_BYTES];

   always_ff @(posedge clk) begin
      if (ld_en) mem_q[ld_addr] <= ld_data;
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tr_cmd_decode.sv
module tr_cmd_decode
   import tr_pkg::*;
#(
   parameter int          NUM_BLOCKS  = 32,
   parameter int          LEN_W       = 5,
   parameter int          BLK_W       = 5,
   parameter logic [7:0]  OP_ACTIVATE = 8'h0A,
   parameter logic [7:0]  OP_READ     = 8'h0C,
   parameter logic [7:0]  OP_READ4    = 8'h06,
   parameter logic [7:0]  OP_UPDATE   = 8'h87,
   parameter logic [63:0] PRESET_B0   = 64'h0,
   parameter logic [63:0] PRESET_B1   = 64'h0,
   parameter logic [63:0] PRESET_B2   = 64'h0,
   parameter logic [63:0] PRESET_B5   = 64'h0
) (
   input  logic             full_mode,
   input  logic [LEN_W-1:0] len,
   input  logic [7:0]       opcode,
   input  logic [7:0]       blk_num,
   output resp_kind_e       kind,
   output logic             burst,
   output logic [BLK_W-1:0] blk_idx,
   output logic [63:0]      preset
);

   localparam logic [LEN_W-1:0] CMD_LEN = LEN_W'(4);

   logic is_key_full;
   logic is_key_raw;

   assign blk_idx     = blk_num[BLK_W-1:0];
   assign is_key_full = (blk_idx == BLK_W'(3)) || (blk_idx == BLK_W'(4));
   assign is_key_raw  = (blk_num == 8'd3) || (blk_num == 8'd4);

   always_comb begin
      unique case (blk_num)
         8'd0:    preset = PRESET_B0;
         8'd1:    preset = PRESET_B1;
         8'd2:    preset = PRESET_B2;
         8'd5:    preset = PRESET_B5;
         default: preset = 64'h0;
      endcase
   end

   always_comb begin
      kind  = RK_NONE;
      burst = 1'b0;
      if (len != '0) begin
         if (opcode == OP_ACTIVATE) begin
            kind = RK_SOF;
         end else if (opcode == OP_READ && len == CMD_LEN) begin
            if (full_mode) begin
               kind = is_key_full ? RK_FF : RK_MEM;
            end else if (is_key_raw) begin
               kind = RK_FF;
            end else if (blk_num == 8'd0 || blk_num == 8'd1 ||
                         blk_num == 8'd2 || blk_num == 8'd5) begin
               kind = RK_PRESET;
            end
         end else if (opcode == OP_READ4 && len == CMD_LEN && full_mode) begin
            kind  = RK_MEM;
            burst = 1'b1;
         end else if (opcode == OP_UPDATE) begin
            kind = RK_NONE;
         end
      end
   end

endmodule

// File: rtl/tag_responder.sv
module tag_responder
   import tr_pkg::*;
#(
   parameter int          NUM_BLOCKS      = 32,
   parameter int          MAX_FRAME_BYTES = 16,
   parameter int          TICK_W          = 32,
   parameter int          REPLY_DELAY     = 132,
   parameter int          PIPE_OFFSET     = 0,
   parameter logic [7:0]  OP_ACTIVATE     = 8'h0A,
   parameter logic [7:0]  OP_READ         = 8'h0C,
   parameter logic [7:0]  OP_READ4        = 8'h06,
   parameter logic [7:0]  OP_UPDATE       = 8'h87,
   parameter logic [63:0] PRESET_B0       = 64'h0123_4567_89AB_CDEF,
   parameter logic [63:0] PRESET_B1       = 64'h0000_FFFF_1200_0C12,
   parameter logic [63:0] PRESET_B2       = 64'hFFFF_FFFF_FFFF_FFFE,
   parameter logic [63:0] PRESET_B5       = 64'hFFFF_FFFF_FFFF_FFFF
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   full_mode,
   input  logic                                   frame_valid,
   output logic                                   frame_ready,
   input  logic [$clog2(MAX_FRAME_BYTES+1)-1:0]   frame_len,
   input  logic [15:0]                            frame_head,
   input  logic [TICK_W-1:0]                      frame_eof_tick,
   input  logic                                   load_en,
   input  logic [$clog2(NUM_BLOCKS*8)-1:0]        load_addr,
   input  logic [7:0]                             load_data,
   output logic                                   tx_valid,
   input  logic                                   tx_ready,
   output logic [7:0]                             tx_data,
   output logic                                   tx_last,
   output logic                                   tx_empty,
   output logic [TICK_W-1:0]                      tx_start_tick
);

   localparam int LEN_W     = $clog2(MAX_FRAME_BYTES + 1);
   localparam int BLK_W     = $clog2(NUM_BLOCKS);
   localparam int MEM_AW    = $clog2(NUM_BLOCKS * 8);
   localparam int NUM_BYTES = NUM_BLOCKS * 8;
   localparam logic [TICK_W-1:0] START_OFS = TICK_W'(REPLY_DELAY - PIPE_OFFSET);
   localparam logic [5:0] LAST_SINGLE = 6'd7;
   localparam logic [5:0] LAST_BURST  = 6'd31;

   generate
      if (NUM_BLOCKS < 8 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
         $error("NUM_BLOCKS must be a power of two of at least 8");
      end
      if (MAX_FRAME_BYTES < 4) begin : g_bad_frame
         $error("MAX_FRAME_BYTES must cover a 4-byte read command");
      end
      if (REPLY_DELAY < PIPE_OFFSET) begin : g_bad_delay
         $error("PIPE_OFFSET must not exceed REPLY_DELAY");
      end
   endgenerate

   resp_kind_e       dec_kind;
   logic             dec_burst;
   logic [BLK_W-1:0] dec_blk;
   logic [63:0]      dec_preset;

   tr_cmd_decode #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .LEN_W      (LEN_W),
      .BLK_W      (BLK_W),
      .OP_ACTIVATE(OP_ACTIVATE),
      .OP_READ    (OP_READ),
      .OP_READ4   (OP_READ4),
      .OP_UPDATE  (OP_UPDATE),
      .PRESET_B0  (PRESET_B0),
      .PRESET_B1  (PRESET_B1),
      .PRESET_B2  (PRESET_B2),
      .PRESET_B5  (PRESET_B5)
   ) u_decode (
      .full_mode (full_mode),
      .len       (frame_len),
      .opcode    (frame_head[7:0]),
      .blk_num   (frame_head[15:8]),
      .kind      (dec_kind),
      .burst     (dec_burst),
      .blk_idx   (dec_blk),
      .preset    (dec_preset)
   );

   seq_state_e        state_q;
   resp_kind_e        kind_q;
   logic              burst_q;
   logic [MEM_AW-1:0] base_q;
   logic [5:0]        idx_q;
   logic [63:0]       preset_q;
   logic [TICK_W-1:0] tick_q;

   logic [7:0]  mem_rd;
   logic [7:0]  src_byte;
   logic [15:0] crc;
   logic        accept;
   logic        beat_done;
   logic        data_last;

   tr_blockmem #(
      .NUM_BYTES (NUM_BYTES),
      .AW        (MEM_AW)
   ) u_mem (
      .clk     (clk),
      .ld_en   (load_en),
      .ld_addr (load_addr),
      .ld_data (load_data),
      .rd_addr (base_q + MEM_AW'(idx_q)),
      .rd_data (mem_rd)
   );

   assign frame_ready = (state_q == ST_IDLE);
   assign accept      = frame_valid && frame_ready;
   assign tx_valid    = (state_q != ST_IDLE);
   assign beat_done   = tx_valid && tx_ready;
   assign data_last   = (idx_q == (burst_q ? LAST_BURST : LAST_SINGLE));

   always_comb begin
      unique case (kind_q)
         RK_FF:     src_byte = 8'hFF;
         RK_PRESET: src_byte = preset_q[8*idx_q[2:0] +: 8];
         RK_MEM:    src_byte = mem_rd;
         default:   src_byte = 8'h00;
      endcase
   end

   tr_crc16 u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .update (beat_done && state_q == ST_DATA),
      .din    (src_byte),
      .crc    (crc)
   );

   always_comb begin
      unique case (state_q)
         ST_DATA: tx_data = src_byte;
         ST_CRC0: tx_data = ~crc[7:0];
         ST_CRC1: tx_data = ~crc[15:8];
         default: tx_data = 8'h00;
      endcase
   end

   assign tx_last       = (state_q == ST_SOF) || (state_q == ST_CRC1);
   assign tx_empty      = (state_q == ST_SOF);
   assign tx_start_tick = tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= RK_NONE;
         burst_q  <= 1'b0;
         base_q   <= '0;
         idx_q    <= '0;
         preset_q <= '0;
         tick_q   <= '0;
      end else if (accept) begin
         kind_q   <= dec_kind;
         burst_q  <= dec_burst;
         base_q   <= {dec_blk, 3'b000};
         idx_q    <= '0;
         preset_q <= dec_preset;
         tick_q   <= frame_eof_tick + START_OFS;
         unique case (dec_kind)
            RK_NONE: state_q <= ST_IDLE;
            RK_SOF:  state_q <= ST_SOF;
            default: state_q <= ST_DATA;
         endcase
      end else if (beat_done) begin
         unique case (state_q)
            ST_SOF:  state_q <= ST_IDLE;
            ST_DATA: begin
               idx_q <= idx_q + 6'd1;
               if (data_last) state_q <= ST_CRC0;
            end
            ST_CRC0: state_q <= ST_CRC1;
            ST_CRC1: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_empty))); // R11

   AST_HOLD_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> $stable(tx_start_tick)); // R9

   AST_BUSY_BLOCKS_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !frame_ready); // R10

   AST_REPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_kind != RK_NONE) |=> tx_valid); // R10

   AST_SILENT_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_kind == RK_NONE) |=> frame_ready); // R7

   AST_SOF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_empty) |-> tx_last); // R1

   AST_KEY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && kind_q == RK_FF && state_q == ST_DATA) |-> (tx_data == 8'hFF)); // R3

endmodule

// File: tb/tag_responder_tb.sv
module tag_responder_tb;

   localparam int NB   = 8;
   localparam int MAXF = 16;
   localparam int TW   = 32;
   localparam int LW   = $clog2(MAXF + 1);
   localparam int AW   = $clog2(NB * 8);
   localparam int DLY  = 132;
   localparam logic [63:0] P0 = 64'h1122_3344_5566_7788;
   localparam logic [63:0] P1 = 64'hA5A5_0F0F_C3C3_9696;
   localparam logic [63:0] P2 = 64'h0102_0408_1020_4080;
   localparam logic [63:0] P5 = 64'hDEAD_BEEF_0BAD_F00D;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          full_mode;
   logic          frame_valid;
   logic          frame_ready;
   logic [LW-1:0] frame_len;
   logic [15:0]   frame_head;
   logic [TW-1:0] frame_eof_tick;
   logic          load_en;
   logic [AW-1:0] load_addr;
   logic [7:0]    load_data;
   logic          tx_valid;
   logic          tx_ready;
   logic [7:0]    tx_data;
   logic          tx_last;
   logic          tx_empty;
   logic [TW-1:0] tx_start_tick;

   always #10 clk = ~clk;

   tag_responder #(
      .NUM_BLOCKS(NB), .MAX_FRAME_BYTES(MAXF), .TICK_W(TW),
      .PRESET_B0(P0), .PRESET_B1(P1), .PRESET_B2(P2), .PRESET_B5(P5)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .full_mode(full_mode),
      .frame_valid(frame_valid), .frame_ready(frame_ready),
      .frame_len(frame_len), .frame_head(frame_head), .frame_eof_tick(frame_eof_tick),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tx_empty(tx_empty), .tx_start_tick(tx_start_tick)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] model_mem [NB*8];
   int    exp_q[$];
   string tag_q[$];
   string cur_req = "R10";
   logic [TW-1:0] exp_tick = '0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;
   logic prev_fr = 1'b1;
   logic prev_tv = 1'b0;
   bit  stall_all = 1'b0;
   logic [7:0] lf = 8'h5A;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c ^ {8'h00, d};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   function automatic void push_payload(input logic [7:0] d[$], input string req);
      logic [15:0] c;
      c = 16'hFFFF;
      foreach (d[i]) begin
         exp_q.push_back(int'(d[i]));
         tag_q.push_back(req);
         c = ref_crc(c, d[i]);
      end
      c = ~c;
      exp_q.push_back(int'(c[7:0]));
      tag_q.push_back("R8");
      exp_q.push_back(int'(c[15:8]));
      tag_q.push_back("R8");
   endfunction

   function automatic void build_expect();
      logic [7:0] op, blk, d[$];
      int wb;
      logic [63:0] pw;
      op = frame_head[7:0];
      blk = frame_head[15:8];
      wb = int'(blk) % NB;
      exp_tick = frame_eof_tick + TW'(DLY);
      d = {};
      if (frame_len == 0) begin
         cur_req = "R1";
      end else if (op == 8'h0A) begin
         cur_req = "R1";
         exp_q.push_back(-1);
         tag_q.push_back("R1");
      end else if (op == 8'h0C) begin
         if (frame_len != 4) begin
            cur_req = "R2";
         end else if ((full_mode && (wb == 3 || wb == 4)) || (!full_mode && (blk == 3 || blk == 4))) begin
            cur_req = (full_mode && blk != 3 && blk != 4) ? "R12" : "R3";
            for (int i = 0; i < 8; i++) d.push_back(8'hFF);
            push_payload(d, cur_req);
         end else if (full_mode) begin
            cur_req = (blk >= NB) ? "R12" : "R4";
            for (int i = 0; i < 8; i++) d.push_back(model_mem[(wb*8+i) % (NB*8)]);
            push_payload(d, cur_req);
         end else begin
            cur_req = "R6";
            case (blk)
               8'd0: pw = P0;
               8'd1: pw = P1;
               8'd2: pw = P2;
               8'd5: pw = P5;
               default: pw = '0;
            endcase
            if (blk == 0 || blk == 1 || blk == 2 || blk == 5) begin
               for (int i = 0; i < 8; i++) d.push_back(pw[8*i +: 8]);
               push_payload(d, cur_req);
            end
         end
      end else if (op == 8'h06) begin
         cur_req = "R5";
         if (full_mode && frame_len == 4) begin
            for (int i = 0; i < 32; i++) d.push_back(model_mem[(wb*8+i) % (NB*8)]);
            push_payload(d, cur_req);
         end
      end else begin
         cur_req = "R7";
      end
   endfunction

   always @(negedge clk) begin
      #1;
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tx_ready <= stall_all ? 1'b0 : (lf[0] | lf[2]);
   end

   always @(negedge clk) begin
      if (mon_on) begin
         bit held;
         string tg;
         held = prev_tv && !tx_ready;
         if (prev_tv && tx_ready && exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (frame_valid && prev_fr) build_expect();
         chk(frame_ready == (exp_q.size() == 0), "R10", frame_ready, exp_q.size() == 0);
         chk(tx_valid == (exp_q.size() != 0), cur_req, tx_valid, exp_q.size() != 0);
         if (tx_valid && exp_q.size() != 0) begin
            tg = held ? {"R11 ", tag_q[0]} : tag_q[0];
            if (exp_q[0] < 0) begin
               chk(tx_empty == 1'b1, tg, tx_empty, 1);
            end else begin
               chk(tx_empty == 1'b0, tg, tx_empty, 0);
               chk(int'(tx_data) == exp_q[0], tg, tx_data, exp_q[0]);
            end
            chk(tx_last == (exp_q.size() == 1), tg, tx_last, exp_q.size() == 1);
            chk(tx_start_tick == exp_tick, held ? "R11 R9" : "R9", tx_start_tick, exp_tick);
         end
         prev_fr = frame_ready;
         prev_tv = tx_valid;
      end
   end

   task automatic idle_wait();
      @(negedge clk); #2;
      while (!frame_ready || exp_q.size() != 0) begin
         @(negedge clk); #2;
      end
      repeat (2) @(negedge clk);
      #2;
   endtask

   task automatic send(input bit fm, input int len, input logic [7:0] op,
                       input logic [7:0] blk, input logic [TW-1:0] tick);
      idle_wait();
      full_mode      = fm;
      frame_len      = LW'(len);
      frame_head     = {blk, op};
      frame_eof_tick = tick;
      frame_valid    = 1'b1;
      @(negedge clk); #2;
      frame_valid    = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; full_mode = 1'b1; frame_valid = 1'b0; frame_len = '0;
      frame_head = '0; frame_eof_tick = '0; load_en = 1'b0; load_addr = '0; load_data = '0;
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk); #2;
      chk(frame_ready == 1'b1, "R10", frame_ready, 1);
      chk(tx_valid == 1'b0, "R10", tx_valid, 0);
      for (int a = 0; a < NB*8; a++) begin
         load_en = 1'b1;
         load_addr = AW'(a);
         load_data = 8'((a * 37 + 11) ^ 8'h3C);
         model_mem[a] = load_data;
         @(negedge clk); #2;
      end
      load_en = 1'b0;
      prev_fr = frame_ready;
      prev_tv = tx_valid;
      mon_on = 1'b1;

      send(1, 4, 8'h0C, 8'd0, 32'd1000);
      send(1, 4, 8'h0C, 8'd1, 32'd2000);
      send(1, 4, 8'h0C, 8'd3, 32'd3000);
      send(1, 4, 8'h0C, 8'd4, 32'd3100);
      send(1, 4, 8'h0C, 8'd5, 32'd3200);
      send(1, 4, 8'h0C, 8'd7, 32'd3300);
      send(1, 4, 8'h0C, 8'd9, 32'd3400);
      send(1, 4, 8'h0C, 8'd11, 32'd3500);
      send(1, 4, 8'h0C, 8'd12, 32'd3600);
      send(1, 3, 8'h0C, 8'd1, 32'd4000);
      send(1, 5, 8'h0C, 8'd1, 32'd4100);
      send(1, 4, 8'h06, 8'd2, 32'd5000);
      send(1, 4, 8'h06, 8'd6, 32'hFFFF_FFF0);
      send(1, 2, 8'h06, 8'd0, 32'd5200);
      send(1, 12, 8'h87, 8'd1, 32'd5300);
      send(1, 4, 8'h55, 8'd1, 32'd5400);
      send(1, 1, 8'h0A, 8'd0, 32'd5500);
      send(1, 0, 8'h0A, 8'd0, 32'd5600);
      send(0, 1, 8'h0A, 8'd0, 32'hFFFF_FFA0);
      for (int b = 0; b < 8; b++) send(0, 4, 8'h0C, 8'(b), 32'(6000 + b * 50));
      send(0, 4, 8'h06, 8'd0, 32'd7000);
      send(0, 12, 8'h87, 8'd2, 32'd7100);
      idle_wait();
      full_mode = 1'b1; frame_len = LW'(4); frame_head = {8'd1, 8'h0C};
      frame_eof_tick = 32'd9000; frame_valid = 1'b1;
      @(negedge clk); #2;
      frame_valid = 1'b0;
      stall_all = 1'b1;
      repeat (6) @(negedge clk);
      #2 stall_all = 1'b0;
      idle_wait();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule